// File: doc/BRIEF.md
# Serial Flash Command Frame Engine

This block turns one command descriptor into one complete serial flash transaction. The descriptor carries an opcode, how many address bytes to send (zero to three), the address value, a count of wait cycles, a transfer direction, a byte count and a lane mode. Once started, the engine lowers chip select and sends the opcode. It then sends the address bytes and runs the wait cycles. Last, it moves the data bytes, either taking them from a byte-wide transmit stream or handing them to a byte-wide receive stream. When the frame closes it raises chip select and gives a single-cycle done pulse.

The serial clock idles low. Output lanes change only while it is low, and input lanes are sampled on its rising edge. Each half period of the serial clock lasts `CLK_DIV` system clocks. Two lane modes exist. In single mode, every phase uses lane 0 outbound and lane 1 inbound. In quad mode, the opcode and address still use lane 0 alone, and the data phase moves one nibble per serial clock across all four lanes. The engine only shapes frames. Choosing which command to issue, polling status and acting on flash errors are left to the controller above it.

Top module: `sflash_frame`

## Requirements
- R1: Out of reset and whenever `busy` is low, `cs_n` is 1, `sclk` is 0 and `io_oe` is 4'b0000.
- R2: Every frame starts with 8 opcode clocks, most significant bit first, on `io_out[0]`, with `io_oe` = 4'b0001.
- R3: After the opcode come `cmd_abytes` (0–3) address bytes. They are the low `8*cmd_abytes` bits of `cmd_addr`, sent most significant bit first on lane 0 with `io_oe` = 4'b0001.
- R4: After the address come exactly `cmd_dummy` wait clocks, always placed before any data clock.
- R5: In single mode (`cmd_quad` = 0) a transmit byte goes out MSB first on `io_out[0]`, and a receive byte is built MSB first from `io_in[1]` sampled on rising `sclk` edges.
- R6: In quad mode a data byte takes two clocks, high nibble first, with nibble bit 3 on lane 3. A quad transmit drives `io_oe` = 4'b1111 during data clocks.
- R7: In a quad receive (`cmd_quad` = 1, `cmd_write` = 0), `io_oe` is 4'b0000 from the first wait clock until `cs_n` rises.
- R8: A frame holds exactly 8 + 8·abytes + dummy + (8 or 2)·len serial clocks. When `cmd_len` is 0, no data clock occurs.
- R9: Data flow control. `sclk` is held low while a transmit byte is awaited (`tx_ready` high). A received byte stays on `rx_data` with `rx_valid` high until `rx_ready` takes it. No byte is lost or repeated.
- R10: A `start` seen while `busy` is high has no effect on the frame in flight and starts no new frame.
- R11: Each frame gives exactly one `done` pulse, issued with `cs_n` already high. `cs_n` stays high for more than one serial clock period (2·`CLK_DIV` system clocks) between frames.
- R12: `io_out` never changes while `sclk` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a frame with the descriptor fields (taken only when idle) |
| cmd_opcode | input | 8 | Opcode byte |
| cmd_abytes | input | 2 | Number of address bytes, 0 to 3 |
| cmd_addr | input | 24 | Address value, low bytes used |
| cmd_dummy | input | DUMMY_W | Number of wait clocks |
| cmd_write | input | 1 | 1: data flows to the flash; 0: data flows from it |
| cmd_quad | input | 1 | 1: data phase on four lanes |
| cmd_len | input | LEN_W | Data byte count, 0 skips the data phase |
| busy | output | 1 | Frame or inter-frame gap in progress |
| done | output | 1 | One-cycle pulse at frame end |
| tx_data | input | 8 | Transmit byte |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Engine is waiting for a transmit byte |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | Received byte available |
| rx_ready | input | 1 | Consumer accepts the received byte |
| cs_n | output | 1 | Chip select, active low |
| sclk | output | 1 | Serial clock |
| io_out | output | 4 | Lane output values |
| io_oe | output | 4 | Lane output enables |
| io_in | input | 4 | Lane input values |

## Verification
The hardest behaviour to reach from the ports is a stall in the middle of a data phase. The serial clock has to freeze with chip select low, either because no transmit byte is ready or because the previous receive byte has not yet been taken. The frame must then resume without a bit slip. To get there, the stimulus drops `tx_valid` and `rx_ready` on random cycles during multi-byte frames, in both lane modes. A bit-level scoreboard then checks every serial clock against the slot sequence expected for that frame. A stray `start` pulsed during a quad receive frame checks that the in-flight frame is not disturbed.

// File: rtl/sflash_frame.sv
module sflash_frame #(
  parameter int CLK_DIV = 2,
  parameter int LEN_W   = 12,
  parameter int DUMMY_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [7:0]         cmd_opcode,
  input  logic [1:0]         cmd_abytes,
  input  logic [23:0]        cmd_addr,
  input  logic [DUMMY_W-1:0] cmd_dummy,
  input  logic               cmd_write,
  input  logic               cmd_quad,
  input  logic [LEN_W-1:0]   cmd_len,
  output logic               busy,
  output logic               done,
  input  logic [7:0]         tx_data,
  input  logic               tx_valid,
  output logic               tx_ready,
  output logic [7:0]         rx_data,
  output logic               rx_valid,
  input  logic               rx_ready,
  output logic               cs_n,
  output logic               sclk,
  output logic [3:0]         io_out,
  output logic [3:0]         io_oe,
  input  logic [3:0]         io_in
);
  localparam int DIV_W = $clog2(2 * CLK_DIV) < 1 ? 1 : $clog2(2 * CLK_DIV);
  localparam int BW    = DUMMY_W > 3 ? DUMMY_W : 3;

  typedef enum logic [2:0] {S_IDLE, S_CMD, S_ADDR, S_DUMMY, S_DATA, S_FIN, S_GAP} phase_t;

  phase_t             phase, nxt;
  logic [DIV_W-1:0]   div;
  logic [BW-1:0]      bits;
  logic [7:0]         sr, rsr;
  logic [23:0]        ar;
  logic [1:0]         a_left;
  logic [DUMMY_W-1:0] q_dummy;
  logic               q_tx, q_quad, need;
  logic [LEN_W-1:0]   len_left;
  logic               sclk_r, cs_r, done_r, rx_valid_r;
  logic [7:0]         rx_data_r;

  wire active  = (phase == S_CMD) || (phase == S_ADDR) || (phase == S_DUMMY) || (phase == S_DATA);
  wire run     = active && !(phase == S_DATA && need);
  wire tick    = (div == DIV_W'(CLK_DIV - 1));
  wire rise    = run && tick && !sclk_r;
  wire fall    = run && tick && sclk_r;
  wire gap_end = (div == DIV_W'(2 * CLK_DIV - 1));
  wire quad_rx = q_quad && !q_tx;

  assign busy     = (phase != S_IDLE);
  assign done     = done_r;
  assign cs_n     = cs_r;
  assign sclk     = sclk_r;
  assign rx_data  = rx_data_r;
  assign rx_valid = rx_valid_r;
  assign tx_ready = (phase == S_DATA) && need && q_tx;
  assign io_out   = (phase == S_DATA && q_quad) ? sr[7:4] : {3'b000, sr[7]};

  always_comb begin
    if (!active && phase != S_FIN)                    io_oe = 4'b0000;
    else if (quad_rx && (phase == S_DUMMY || phase == S_DATA || phase == S_FIN))
                                                      io_oe = 4'b0000;
    else if (q_quad && q_tx && phase == S_DATA)       io_oe = 4'b1111;
    else                                              io_oe = 4'b0001;
  end

  always_comb begin
    nxt = S_FIN;
    if (phase == S_CMD && a_left != 2'd0)                             nxt = S_ADDR;
    else if ((phase == S_CMD || phase == S_ADDR) && q_dummy != '0)    nxt = S_DUMMY;
    else if (phase != S_DATA && len_left != '0)                       nxt = S_DATA;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= S_IDLE; div <= '0; bits <= '0; sr <= '0; rsr <= '0; ar <= '0;
      a_left <= '0; q_dummy <= '0; q_tx <= 1'b0; q_quad <= 1'b0; need <= 1'b0;
      len_left <= '0; sclk_r <= 1'b0; cs_r <= 1'b1; done_r <= 1'b0;
      rx_valid_r <= 1'b0; rx_data_r <= '0;
    end else begin
      done_r <= 1'b0;
      if (rx_valid_r && rx_ready) rx_valid_r <= 1'b0;
      if (run) begin
        div <= tick ? '0 : div + 1'b1;
        if (tick) sclk_r <= ~sclk_r;
      end
      if (rise) rsr <= q_quad ? {rsr[3:0], io_in} : {rsr[6:0], io_in[1]};
      case (phase)
        S_IDLE: if (start) begin
          phase    <= S_CMD;
          cs_r     <= 1'b0;
          sclk_r   <= 1'b0;
          div      <= '0;
          sr       <= cmd_opcode;
          bits     <= BW'(7);
          a_left   <= cmd_abytes;
          q_dummy  <= cmd_dummy;
          q_tx     <= cmd_write;
          q_quad   <= cmd_quad;
          len_left <= cmd_len;
          need     <= 1'b0;
          case (cmd_abytes)
            2'd1:    ar <= {cmd_addr[7:0], 16'h0000};
            2'd2:    ar <= {cmd_addr[15:0], 8'h00};
            default: ar <= cmd_addr;
          endcase
        end
        S_CMD, S_ADDR, S_DUMMY, S_DATA: begin
          if (phase == S_DATA && need) begin
            if (q_tx ? tx_valid : !rx_valid_r) begin
              need <= 1'b0;
              bits <= q_quad ? BW'(1) : BW'(7);
              if (q_tx) sr <= tx_data;
            end
          end else if (fall) begin
            if (bits != '0) begin
              bits <= bits - 1'b1;
              sr   <= (phase == S_DATA && q_quad) ? {sr[3:0], 4'h0} : {sr[6:0], 1'b0};
            end else if (phase == S_ADDR && a_left != 2'd0) begin
              sr     <= ar[23:16];
              ar     <= {ar[15:0], 8'h00};
              a_left <= a_left - 1'b1;
              bits   <= BW'(7);
            end else if (phase == S_DATA) begin
              if (!q_tx) begin
                rx_data_r  <= rsr;
                rx_valid_r <= 1'b1;
              end
              len_left <= len_left - 1'b1;
              if (len_left == LEN_W'(1)) phase <= S_FIN;
              else                       need  <= 1'b1;
            end else begin
              phase <= nxt;
              case (nxt)
                S_ADDR: begin
                  sr     <= ar[23:16];
                  ar     <= {ar[15:0], 8'h00};
                  a_left <= a_left - 1'b1;
                  bits   <= BW'(7);
                end
                S_DUMMY: begin
                  sr   <= 8'h00;
                  bits <= BW'(q_dummy - 1'b1);
                end
                S_DATA:  need <= 1'b1;
                default: ;
              endcase
            end
          end
        end
        S_FIN: begin
          cs_r   <= 1'b1;
          done_r <= 1'b1;
          div    <= '0;
          phase  <= S_GAP;
        end
        S_GAP: begin
          if (gap_end) phase <= S_IDLE;
          else         div   <= div + 1'b1;
        end
        default: phase <= S_IDLE;
      endcase
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (cs_n && !sclk && io_oe == 4'b0000)); // R1
  AST_OUT_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(io_out)); // R12
  AST_QUAD_RX_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && $past(!cs_n) && quad_rx && $past(io_oe) == 4'b0000) |-> io_oe == 4'b0000); // R7
  AST_DONE_AFTER_CS: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cs_n); // R11
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable({q_tx, q_quad, q_dummy})); // R10
  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data))); // R9
  AST_TX_WAIT_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> !sclk); // R9
endmodule

// File: tb/test_sflash_frame.sv
`timescale 1ns/1ps
module test_sflash_frame;
  localparam int CLK_DIV = 2;
  localparam int LEN_W   = 12;
  localparam int DUMMY_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [7:0] cmd_opcode = '0;
  logic [1:0] cmd_abytes = '0;
  logic [23:0] cmd_addr = '0;
  logic [DUMMY_W-1:0] cmd_dummy = '0;
  logic cmd_write = 1'b0, cmd_quad = 1'b0;
  logic [LEN_W-1:0] cmd_len = '0;
  logic busy, done, tx_ready, rx_valid, cs_n, sclk;
  logic [7:0] tx_data = '0;
  logic tx_valid = 1'b0;
  logic [7:0] rx_data;
  logic rx_ready = 1'b0;
  logic [3:0] io_out, io_oe;
  logic [3:0] io_in = '0;

  always #2 clk = ~clk;

  sflash_frame #(.CLK_DIV(CLK_DIV), .LEN_W(LEN_W), .DUMMY_W(DUMMY_W)) i_sflash_frame (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_opcode(cmd_opcode), .cmd_abytes(cmd_abytes),
    .cmd_addr(cmd_addr), .cmd_dummy(cmd_dummy), .cmd_write(cmd_write), .cmd_quad(cmd_quad),
    .cmd_len(cmd_len), .busy(busy), .done(done), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .cs_n(cs_n), .sclk(sclk), .io_out(io_out), .io_oe(io_oe), .io_in(io_in));

  typedef struct {
    logic [3:0] oe;
    logic [3:0] val;
    logic [3:0] mask;
    logic [3:0] drv;
    string      tag;
  } slot_t;

  slot_t      sq[$];
  logic [7:0] txq[$];
  logic [7:0] rxq[$];
  int n_chk = 0, n_fail = 0, done_cnt = 0, frames = 0, hi_cnt = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic push_slot(input logic [3:0] oe, input logic [3:0] val,
                           input logic [3:0] mask, input logic [3:0] drv, input string tag);
    slot_t s;
    s.oe = oe; s.val = val; s.mask = mask; s.drv = drv; s.tag = tag;
    sq.push_back(s);
  endtask

  task automatic push_byte1(input logic [7:0] b, input string tag);
    for (int i = 7; i >= 0; i--) push_slot(4'b0001, {3'b000, b[i]}, 4'b0001, 4'b0000, tag);
  endtask

  // monitor: one expected slot per rising serial clock edge
  always @(posedge sclk) begin
    slot_t s;
    if (!cs_n) begin
      if (sq.size() == 0) check(1'b0, "R8 extra serial clock", 1, 0);
      else begin
        s = sq.pop_front();
        check(io_oe == s.oe, {s.tag, " lane enables"}, io_oe, s.oe);
        check((io_out & s.mask) == (s.val & s.mask), {s.tag, " lane values"},
              io_out & s.mask, s.val & s.mask);
      end
    end
  end

  // flash model: present the next slot's input value after each falling edge
  always @(negedge sclk or negedge cs_n) begin
    if (sq.size() != 0) io_in = sq[0].drv;
    else io_in = 4'h0;
  end

  // transmit source with random gaps
  always @(negedge clk) begin
    tx_valid = (txq.size() != 0) && ($urandom % 4 != 0);
    tx_data  = (txq.size() != 0) ? txq[0] : 8'h00;
    if (tx_valid && tx_ready) void'(txq.pop_front());
  end

  // receive sink with random back-pressure
  always @(negedge clk) begin
    logic [7:0] e;
    rx_ready = ($urandom % 3 != 0);
    if (rx_ready && rx_valid) begin
      if (rxq.size() == 0) check(1'b0, "R9 unexpected receive byte", rx_data, 0);
      else begin
        e = rxq.pop_front();
        check(rx_data == e, "R9 R5 R6 received byte", rx_data, e);
      end
    end
  end

  // done pulses and chip-select gap
  always @(negedge clk) begin
    if (done) begin
      done_cnt++;
      check(cs_n == 1'b1, "R11 done with cs_n high", cs_n, 1);
    end
    if (cs_n) hi_cnt++;
    else begin
      if (hi_cnt != 0) check(hi_cnt > 2 * CLK_DIV, "R11 cs_n high gap", hi_cnt, 2 * CLK_DIV + 1);
      hi_cnt = 0;
    end
  end

  task automatic frame(input logic [7:0] op, input int nab, input logic [23:0] addr,
                       input int dmy, input bit wr, input bit quad, input int len, input bit poke);
    logic [7:0] b;
    push_byte1(op, "R2 opcode");
    for (int i = nab - 1; i >= 0; i--) push_byte1(addr[8*i +: 8], "R3 address");
    for (int i = 0; i < dmy; i++)
      push_slot((quad && !wr) ? 4'b0000 : 4'b0001, 4'h0, 4'h0, 4'h0, "R4 R7 wait clock");
    for (int k = 0; k < len; k++) begin
      b = 8'($urandom);
      if (wr) begin
        txq.push_back(b);
        if (quad) begin
          push_slot(4'b1111, b[7:4], 4'b1111, 4'h0, "R6 quad transmit");
          push_slot(4'b1111, b[3:0], 4'b1111, 4'h0, "R6 quad transmit");
        end else push_byte1(b, "R5 single transmit");
      end else begin
        rxq.push_back(b);
        if (quad) begin
          push_slot(4'b0000, 4'h0, 4'h0, b[7:4], "R7 quad receive");
          push_slot(4'b0000, 4'h0, 4'h0, b[3:0], "R7 quad receive");
        end else
          for (int i = 7; i >= 0; i--) push_slot(4'b0001, 4'h0, 4'h0, {2'b00, b[i], 1'b0}, "R5 single receive");
      end
    end
    @(negedge clk);
    cmd_opcode = op; cmd_abytes = 2'(nab); cmd_addr = addr; cmd_dummy = DUMMY_W'(dmy);
    cmd_write = wr; cmd_quad = quad; cmd_len = LEN_W'(len); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    frames++;
    if (poke) begin
      repeat (20) @(negedge clk);
      cmd_opcode = 8'hA5; cmd_abytes = 2'd0; cmd_dummy = '0; cmd_write = 1'b1;
      cmd_quad = 1'b0; cmd_len = '0; start = 1'b1;   // R10 stray start while busy
      @(negedge clk);
      start = 1'b0;
    end
    while (done_cnt < frames) @(negedge clk);
    while (busy) @(negedge clk);
    check(done_cnt == frames, "R10 R11 one done per frame", done_cnt, frames);
    check(sq.size() == 0, "R8 serial clock count", sq.size(), 0);
    check(txq.size() == 0, "R9 transmit bytes consumed", txq.size(), 0);
    for (int i = 0; i < 200 && rxq.size() != 0; i++) @(negedge clk);
    check(rxq.size() == 0, "R9 receive bytes delivered", rxq.size(), 0);
    check(cs_n == 1'b1 && sclk == 1'b0 && io_oe == 4'b0000, "R1 idle between frames",
          {cs_n, sclk, io_oe}, 6'b100000);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual expired expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(cs_n == 1'b1, "R1 reset cs_n", cs_n, 1);
    check(sclk == 1'b0, "R1 reset sclk", sclk, 0);
    check(io_oe == 4'b0000, "R1 reset lane enables", io_oe, 0);
    check(busy == 1'b0, "R1 reset busy", busy, 0);
    frame(8'hFF, 0, 24'h0, 0, 1'b0, 1'b0, 0, 1'b0);      // R8 bare opcode
    frame(8'h06, 0, 24'h0, 0, 1'b1, 1'b0, 0, 1'b0);
    frame(8'h13, 3, 24'h01A2B3, 0, 1'b0, 1'b0, 0, 1'b0); // R3 three bytes
    frame(8'h0B, 2, 24'h00_0123, 8, 1'b0, 1'b0, 4, 1'b0); // R4 R5
    frame(8'h6B, 2, 24'h00_0456, 8, 1'b0, 1'b1, 6, 1'b1); // R6 R7 R10
    frame(8'h02, 2, 24'h00_0789, 0, 1'b1, 1'b0, 5, 1'b0); // R5 transmit
    frame(8'h32, 2, 24'h00_0ABC, 0, 1'b1, 1'b1, 7, 1'b0); // R6 quad transmit
    frame(8'h5A, 1, 24'h0000C3, 3, 1'b0, 1'b0, 1, 1'b0); // R3 one byte, R4 short wait
    frame(8'h6B, 2, 24'h00_0DEF, 2, 1'b0, 1'b1, 9, 1'b0); // R9 stalls
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule